// File: doc/BRIEF.md
# Frame-Gated Network Tile Interface

This block lets a frame-oriented processing kernel sit on a packet-switched on-chip network as an ordinary client. Payload words arrive on a valid/ready receive port and are written into one of two frame buffers. The kernel is launched only once a whole frame is in a buffer. When the kernel reports that it has finished, the block sends the frame out on a valid/ready send port as a single packet. The packet starts with a routing header that carries the destination tile coordinates and the payload length, and the payload words follow.

The two buffers alternate. One buffer can take in a new frame while the other is waiting for the kernel, being processed or being sent. When both buffers are occupied, the receive port holds off new words until a packet has left. In this project the kernel is a placeholder with a fixed latency and no change to the data, so each outgoing payload equals the incoming frame. The kernel's start and done handshake is brought out for observation.

Top module: `frame_tile_if`

## Requirements
- R1: After a synchronous active-high reset, `in_ready` is 1, `out_valid` is 0 and `kern_start` is 0.
- R2: A receive word is stored only on a cycle where `in_valid` and `in_ready` are both 1. Data present while `in_valid` is 0 never appears in an outgoing payload.
- R3: `kern_start` pulses for a frame only after all FRAME_LEN words of that frame have been accepted. `kern_buf` names the buffer, and successive starts alternate 0, 1, 0, ... from reset.
- R4: Each packet is one header word followed by exactly FRAME_LEN payload words in arrival order. The header places dst_x in the top COORD_W bits, dst_y in the next COORD_W bits below them, and FRAME_LEN in the low $clog2(FRAME_LEN+1) bits, with all other bits 0.
- R5: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` at 1 and an unchanged `out_data`.
- R6: With two received frames not yet fully sent, `in_ready` is 0. No word of a third frame is accepted before the last payload word of the oldest packet has been transferred.
- R7: Packets leave in the order in which their frames completed.
- R8: Any pattern of gaps on `in_valid` or stalls on `out_ready` gives the same packet contents.
- R9: A reset in the middle of a packet drops `out_valid` and raises `in_ready`. The next packet again starts with a header.
- R10: No packet word is offered before `kern_done` has pulsed for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dst_x | input | COORD_W | Destination tile column written into the header |
| dst_y | input | COORD_W | Destination tile row written into the header |
| in_valid | input | 1 | Receive word present |
| in_ready | output | 1 | Receive word can be taken |
| in_data | input | DATA_W | Receive payload word |
| out_valid | output | 1 | Send word present |
| out_ready | input | 1 | Network takes the send word |
| out_data | output | DATA_W | Header or payload word |
| kern_start | output | 1 | Kernel launch pulse |
| kern_buf | output | 1 | Buffer index handed to the kernel |
| kern_done | output | 1 | Kernel completion pulse |

## Verification
The bench sends four kinds of traffic. The first is a frame with no gaps into a sink that never stalls, which fixes the header format and the word order. The second is a frame with idle gaps carrying junk data, sent into a sink that stalls periodically. It shows whether junk is ever captured and whether the send port holds its word during a stall. The third is three frames sent back to back while the sink is closed. It separates a correct two-buffer hold-off from overrun, and correct delivery order from reordering. The last is a reset in the middle of a packet followed by a fresh frame. It shows whether the send logic truly returns to idle and starts the next packet with a header.

// File: rtl/frame_tile_pkg.sv
package frame_tile_pkg;
  typedef enum logic [2:0] {
    BUF_FREE, BUF_FULL, BUF_PROC, BUF_DONE, BUF_SEND
  } buf_st_e;

  typedef enum logic [1:0] {TX_IDLE, TX_HDR, TX_PAY} tx_st_e;

  function automatic logic other_buf(input logic b);
    return ~b;
  endfunction
endpackage

// File: rtl/frame_rx.sv
module frame_rx import frame_tile_pkg::*; #(
  parameter int DATA_W    = 32,
  parameter int FRAME_LEN = 2048,
  localparam int CNT_W    = $clog2(FRAME_LEN),
  localparam int ADDR_W   = $clog2(2 * FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              slot_free,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_sel,
  output logic              frame_done
);
  logic [CNT_W-1:0] cnt;
  logic             last;

  function automatic logic [ADDR_W-1:0] slot_addr(input logic sel, input logic [CNT_W-1:0] idx);
    return (sel ? ADDR_W'(FRAME_LEN) : '0) + ADDR_W'(idx);
  endfunction

  assign in_ready   = slot_free;
  assign wr_en      = in_valid && in_ready;
  assign wr_addr    = slot_addr(wr_sel, cnt);
  assign wr_data    = in_data;
  assign last       = (cnt == CNT_W'(FRAME_LEN - 1));
  assign frame_done = wr_en && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      wr_sel <= 1'b0;
    end else if (wr_en) begin
      if (last) begin
        cnt    <= '0;
        wr_sel <= other_buf(wr_sel);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/frame_kernel_stub.sv
module frame_kernel_stub #(
  parameter int KERN_LAT = 4,
  localparam int LAT_W   = $clog2(KERN_LAT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_buf,
  output logic busy,
  output logic done,
  output logic done_buf
);
  logic [LAT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      done_buf <= 1'b0;
      cnt      <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        done_buf <= start_buf;
        cnt      <= '0;
      end else if (busy) begin
        if (cnt == LAT_W'(KERN_LAT - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frame_tx.sv
module frame_tx import frame_tile_pkg::*; #(
  parameter int DATA_W    = 32,
  parameter int FRAME_LEN = 2048,
  parameter int COORD_W   = 4,
  localparam int CNT_W    = $clog2(FRAME_LEN),
  localparam int ADDR_W   = $clog2(2 * FRAME_LEN),
  localparam int LEN_W    = $clog2(FRAME_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic               send_ok,
  input  logic [DATA_W-1:0]  rd_data,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               tx_sel,
  output logic               pkt_start,
  output logic               pkt_end
);
  tx_st_e           st;
  logic [CNT_W-1:0] cnt;
  logic             fire;

  function automatic logic [DATA_W-1:0] make_hdr(input logic [COORD_W-1:0] x, input logic [COORD_W-1:0] y);
    logic [DATA_W-1:0] h;
    h = '0;
    h[DATA_W-1 -: COORD_W]           = x;
    h[DATA_W-1-COORD_W -: COORD_W]   = y;
    h[LEN_W-1:0]                     = LEN_W'(FRAME_LEN);
    return h;
  endfunction

  assign rd_addr   = (tx_sel ? ADDR_W'(FRAME_LEN) : '0) + ADDR_W'(cnt);
  assign out_valid = (st != TX_IDLE);
  assign out_data  = (st == TX_HDR) ? make_hdr(dst_x, dst_y) : rd_data;
  assign fire      = out_valid && out_ready;
  assign pkt_start = (st == TX_IDLE) && send_ok;
  assign pkt_end   = fire && (st == TX_PAY) && (cnt == CNT_W'(FRAME_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= TX_IDLE;
      cnt    <= '0;
      tx_sel <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: if (send_ok) st <= TX_HDR;
        TX_HDR:  if (fire) begin
          st  <= TX_PAY;
          cnt <= '0;
        end
        default: if (fire) begin
          if (pkt_end) begin
            st     <= TX_IDLE;
            cnt    <= '0;
            tx_sel <= other_buf(tx_sel);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/frame_tile_if.sv
module frame_tile_if import frame_tile_pkg::*; #(
  parameter int DATA_W    = 32,
  parameter int FRAME_LEN = 2048,
  parameter int COORD_W   = 4,
  parameter int KERN_LAT  = 4,
  localparam int NBUF     = 2,
  localparam int ADDR_W   = $clog2(NBUF * FRAME_LEN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic               kern_start,
  output logic               kern_buf,
  output logic               kern_done
);
  logic [DATA_W-1:0] mem [NBUF*FRAME_LEN];
  buf_st_e           st [NBUF];

  logic              wr_en, rx_sel, rx_free, rx_frame_done;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              proc_sel, k_busy, k_done_buf;
  logic              tx_sel, tx_ok, tx_pkt_start, tx_pkt_end;

  assign rx_free    = (st[rx_sel] == BUF_FREE);
  assign tx_ok      = (st[tx_sel] == BUF_DONE);
  assign kern_start = !k_busy && (st[proc_sel] == BUF_FULL);
  assign kern_buf   = proc_sel;

  frame_rx #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) u_rx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .slot_free(rx_free), .in_ready(in_ready), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_sel(rx_sel),
    .frame_done(rx_frame_done)
  );

  frame_kernel_stub #(.KERN_LAT(KERN_LAT)) u_kern (
    .clk(clk), .rst(rst), .start(kern_start), .start_buf(proc_sel),
    .busy(k_busy), .done(kern_done), .done_buf(k_done_buf)
  );

  frame_tx #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .COORD_W(COORD_W)) u_tx (
    .clk(clk), .rst(rst), .dst_x(dst_x), .dst_y(dst_y), .send_ok(tx_ok),
    .rd_data(rd_data), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .rd_addr(rd_addr), .tx_sel(tx_sel),
    .pkt_start(tx_pkt_start), .pkt_end(tx_pkt_end)
  );

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (rst)             proc_sel <= 1'b0;
    else if (kern_start) proc_sel <= other_buf(proc_sel);
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    always_ff @(posedge clk) begin
      if (rst)                                      st[b] <= BUF_FREE;
      else if (rx_frame_done && rx_sel == 1'(b))    st[b] <= BUF_FULL;
      else if (kern_start && proc_sel == 1'(b))     st[b] <= BUF_PROC;
      else if (kern_done && k_done_buf == 1'(b))    st[b] <= BUF_DONE;
      else if (tx_pkt_start && tx_sel == 1'(b))     st[b] <= BUF_SEND;
      else if (tx_pkt_end && tx_sel == 1'(b))       st[b] <= BUF_FREE;
    end
  end
endmodule

// File: rtl/frame_tile_if_chk.sv
module frame_tile_if_chk #(
  parameter int DATA_W    = 32,
  parameter int FRAME_LEN = 2048,
  parameter int COORD_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [COORD_W-1:0] dst_x,
  input logic [COORD_W-1:0] dst_y,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [DATA_W-1:0]  out_data,
  input logic               kern_start,
  input logic               kern_done,
  input logic               rx_frame_done,
  input logic               tx_pkt_end
);
  logic [31:0]       frames_in, starts, dones, pkts_out;
  logic              at_start;
  logic [DATA_W-1:0] exp_hdr;

  assign exp_hdr = (DATA_W'({dst_x, dst_y}) << (DATA_W - 2 * COORD_W)) | DATA_W'(FRAME_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      frames_in <= '0; starts <= '0; dones <= '0; pkts_out <= '0;
      at_start  <= 1'b1;
    end else begin
      frames_in <= frames_in + 32'(rx_frame_done);
      starts    <= starts + 32'(kern_start);
      dones     <= dones + 32'(kern_done);
      pkts_out  <= pkts_out + 32'(tx_pkt_end);
      if (tx_pkt_end)                  at_start <= 1'b1;
      else if (out_valid && out_ready) at_start <= 1'b0;
    end
  end

  // R3
  kstart_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
    kern_start |-> (frames_in > starts));

  // R6
  full_holdoff_chk: assert property (@(posedge clk) disable iff (rst)
    (frames_in - pkts_out == 32'd2) |-> !in_ready);

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4
  header_first_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && at_start) |-> (out_data == exp_hdr));

  // R10
  done_before_send_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (dones > pkts_out));
endmodule

bind frame_tile_if frame_tile_if_chk #(
  .DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .COORD_W(COORD_W)
) u_chk (
  .clk(clk), .rst(rst), .dst_x(dst_x), .dst_y(dst_y), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .kern_start(kern_start), .kern_done(kern_done),
  .rx_frame_done(rx_frame_done), .tx_pkt_end(tx_pkt_end)
);

// File: tb/frame_tile_if_test.sv
module frame_tile_if_test;
  localparam int FL  = 8;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  dst_x = 4'hA, dst_y = 4'h5;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, kern_start, kern_buf, kern_done;
  logic [31:0] out_data;

  int checks = 0, fails = 0;
  int words_in = 0, starts = 0, dones = 0, pkts_seen = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  frame_tile_if #(.DATA_W(32), .FRAME_LEN(FL), .COORD_W(4), .KERN_LAT(LAT)) uut (
    .clk(clk), .rst(rst), .dst_x(dst_x), .dst_y(dst_y),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .kern_start(kern_start), .kern_buf(kern_buf), .kern_done(kern_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr_of(input logic [3:0] x, input logic [3:0] y);
    return 32'(x) * 32'h1000_0000 + 32'(y) * 32'h0100_0000 + 32'(FL);
  endfunction

  // kernel handshake monitor (R3, R10 support)
  always @(negedge clk) begin
    #2;
    if (!rst && kern_start) begin
      chk(words_in >= (starts + 1) * FL, "R3 start before full frame", 32'(words_in), 32'((starts + 1) * FL));
      chk(kern_buf == 1'(starts % 2), "R3 start buffer index", 32'(kern_buf), 32'(starts % 2));
      starts++;
    end
    if (!rst && kern_done) dones++;
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk); rst = 1'b0;
    words_in = 0; starts = 0; dones = 0; pkts_seen = 0;
  endtask

  task automatic put_word(input logic [31:0] w);
    @(negedge clk); in_valid = 1'b1; in_data = w; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    words_in++;
  endtask

  task automatic drive_frame(input logic [31:0] base, input int gap);
    for (int i = 0; i < FL; i++) begin
      if (gap != 0 && (i % gap) == 1) begin
        @(negedge clk); in_valid = 1'b0; in_data = 32'hBAD0_0000 | 32'(i);
        @(negedge clk); in_data = 32'hBAD1_0000 | 32'(i);
      end
      put_word(base + 32'(i));
    end
    @(negedge clk); in_valid = 1'b0; in_data = 32'hDEAD_BEEF;
  endtask

  // receive up to 'upto' words (header counts as one); stall every 'smod'-th cycle
  task automatic get_pkt(input logic [31:0] base, input int smod, input int upto, input string req);
    int k = 0; int cyc = 0; bit held = 0; bit first = 1; logic [31:0] hv = '0;
    logic [31:0] exp;
    while (k < upto) begin
      @(negedge clk);
      out_ready = (smod == 0) || ((cyc % smod) != 0);
      cyc++;
      #1;
      if (held) chk(out_valid && out_data == hv, "R5 held word changed", out_data, hv);
      held = 0;
      if (out_valid) begin
        if (first) begin
          chk(dones > pkts_seen, "R10 word before kernel done", 32'(dones), 32'(pkts_seen + 1));
          first = 0;
        end
        if (out_ready) begin
          exp = (k == 0) ? hdr_of(dst_x, dst_y) : base + 32'(k - 1);
          chk(out_data == exp, req, out_data, exp);
          k++;
        end else begin
          held = 1; hv = out_data;
        end
      end
    end
    @(negedge clk); out_ready = 1'b0;
    if (upto == FL + 1) pkts_seen++;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk(kern_start == 1'b0, "R1 kern_start after reset", 32'(kern_start), 32'd0);
  endtask

  task automatic t_basic();
    drive_frame(32'h0000_0100, 0);
    get_pkt(32'h0000_0100, 0, FL + 1, "R4 basic packet");
  endtask

  task automatic t_gaps();
    dst_x = 4'h3; dst_y = 4'hC;
    fork
      drive_frame(32'h0000_0200, 2);
      get_pkt(32'h0000_0200, 3, FL + 1, "R8 R2 gapped/stalled packet");
    join
  endtask

  task automatic t_pingpong();
    int base_w;
    base_w = words_in;
    drive_frame(32'h0000_1000, 0);
    drive_frame(32'h0000_2000, 0);
    repeat (10) @(negedge clk);
    #1;
    chk(in_ready == 1'b0, "R6 in_ready with both buffers held", 32'(in_ready), 32'd0);
    fork
      drive_frame(32'h0000_3000, 1);
      begin
        get_pkt(32'h0000_1000, 0, FL + 1, "R7 first packet");
        chk(words_in - base_w == 2 * FL, "R6 third frame accepted early", 32'(words_in - base_w), 32'(2 * FL));
        get_pkt(32'h0000_2000, 4, FL + 1, "R7 second packet");
        get_pkt(32'h0000_3000, 0, FL + 1, "R7 third packet");
      end
    join
  endtask

  task automatic t_reset_mid();
    drive_frame(32'h0000_4000, 0);
    get_pkt(32'h0000_4000, 0, 3, "R4 partial packet");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    words_in = 0; starts = 0; dones = 0; pkts_seen = 0;
    #1;
    chk(out_valid == 1'b0, "R9 out_valid after mid reset", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R9 in_ready after mid reset", 32'(in_ready), 32'd1);
    drive_frame(32'h0000_5000, 0);
    get_pkt(32'h0000_5000, 2, FL + 1, "R9 packet after reset");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_gaps();
    t_pingpong();
    t_reset_mid();
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule